// File: doc/BRIEF.md
# Frame-Multiplexed Overrange Flag Output

This block turns per-sample overrange indications from a stereo converter into one active-low status line shared by both channels. The line is time-multiplexed by the left/right frame clock, so each half-frame carries one channel's status. A receiver recovers the two flags by latching the line on the frame clock edges.

Each channel has a sticky flag that is set when an overrange is reported on a sample strobe. The flag stays set through a hold window counted in output samples, so that a slow observer still sees it. The window is a base count scaled by the speed mode, which keeps its length in milliseconds roughly constant across sample rates. An overrange on either channel reloads the shared window, so both flags are released together.

The line value is updated a fixed number of serial bit periods after each frame clock transition. That delay is one bit period in left-justified format and two in I2S format, which leaves ample setup time before the latching edge. The output is an open-drain style enable: it pulls the line low or releases it, and it never drives the line high.

Top module: `clip_flag_serializer`

## Requirements
- R1: While `rst_n` is low and after its release, `line_pull_low` is 0 (line released) until an overrange has been reported.
- R2: A channel's flag is set only on a cycle where `sample_stb` is 1 and that channel's overrange input is 1. An overrange input that is high while `sample_stb` is 0 has no effect.
- R3: The hold window is HOLD_BASE × scale sample strobes, with scale 1 for `speed_mode`=0, 2 for 1, 4 for 2 and 1 for the reserved value 3. A flag set on strobe k is cleared on strobe k+window if no overrange occurs on strobes k+1 to k+window.
- R4: An overrange on either channel at a sample strobe restarts the window for both flags. Both flags clear on the same strobe, and a channel with no overrange of its own is never set by the other channel.
- R5: With `fmt_i2s`=0 (left-justified), the half-frame with `lrck`=1 carries the left flag and the half-frame with `lrck`=0 carries the right flag. With `fmt_i2s`=1 (I2S), this assignment is reversed.
- R6: The block samples `lrck` on each `sclk_stb` cycle. When a sampled value differs from the previous one, the output is reloaded on the 1st following `sclk_stb` (left-justified) or the 2nd (I2S), and it holds that value until the next reload.
- R7: `line_pull_low`=1 means the line is pulled low and 0 means it is released. After a reload, the output equals the flag of the channel selected for that half-frame, as sampled at the reload cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_stb | input | 1 | One-cycle strobe per serial bit period, at the bit-clock edge where the line may change |
| lrck | input | 1 | Frame clock level |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = left-justified framing |
| speed_mode | input | 2 | 0 single, 1 double, 2 quad, 3 reserved (treated as single) |
| sample_stb | input | 1 | One-cycle strobe per output sample frame; overrange inputs are qualified by it |
| ovr_left | input | 1 | Left channel overrange for the current sample |
| ovr_right | input | 1 | Right channel overrange for the current sample |
| line_pull_low | output | 1 | 1 = pull the shared status line low, 0 = release it |

## Verification
A wrong hold count or a missed window restart shows at the line as a half-frame that is released too early or held too long, so the error is visible within one frame of the true expiry point. A wrong channel select or format polarity swaps the two half-frames as soon as only one channel is flagged. A wrong reload delay moves the line transition by one bit-clock strobe relative to the frame edge. The reference model follows the line on every clock, so each of these faults is reported on the first cycle in which the line differs.

// File: rtl/clip_flag_pkg.sv
package clip_flag_pkg;

   localparam int NUM_CH = 2;
   localparam int CH_L   = 0;
   localparam int CH_R   = 1;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'd0,
      SPD_DOUBLE = 2'd1,
      SPD_QUAD   = 2'd2,
      SPD_RSVD   = 2'd3
   } speed_e;

   // left shift applied to the base hold count for each speed mode
   function automatic logic [1:0] speed_shift(input logic [1:0] mode);
      case (speed_e'(mode))
         SPD_DOUBLE: speed_shift = 2'd1;
         SPD_QUAD:   speed_shift = 2'd2;
         default:    speed_shift = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/clip_hold_timer.sv
module clip_hold_timer
   import clip_flag_pkg::*;
#(
   parameter int HOLD_BASE = 32768,
   parameter int CNT_W     = $clog2(HOLD_BASE * 4 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic [NUM_CH-1:0] ovr,
   input  logic [1:0]        speed_mode,
   output logic [NUM_CH-1:0] flags
);

   if (HOLD_BASE < 1) begin : g_bad_base
      $error("clip_hold_timer: HOLD_BASE must be at least 1");
   end
   if (CNT_W < $clog2(HOLD_BASE * 4 + 1)) begin : g_bad_width
      $error("clip_hold_timer: CNT_W too narrow for the quad-speed window");
   end

   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] window;
   logic             any_ovr;
   logic             expire;

   assign window  = CNT_W'(HOLD_BASE) << speed_shift(speed_mode);
   assign any_ovr = |ovr;
   assign expire  = sample_stb && !any_ovr && (remain == CNT_W'(1));

   // shared window counter: any channel reloads it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (sample_stb) begin
         if (any_ovr)
            remain <= window;
         else if (remain != '0)
            remain <= remain - CNT_W'(1);
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[c] <= 1'b0;
         else if (sample_stb && ovr[c])
            flags[c] <= 1'b1;
         else if (expire)
            flags[c] <= 1'b0;
      end
   end

endmodule

// File: rtl/clip_slot_mux.sv
module clip_slot_mux
   import clip_flag_pkg::*;
#(
   parameter int LJ_DELAY  = 1,
   parameter int I2S_DELAY = 2,
   parameter int MAX_DELAY = (LJ_DELAY > I2S_DELAY) ? LJ_DELAY : I2S_DELAY,
   parameter int TMR_W     = $clog2(MAX_DELAY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_stb,
   input  logic              lrck,
   input  logic              fmt_i2s,
   input  logic [NUM_CH-1:0] flags,
   output logic              line_pull_low
);

   if (LJ_DELAY < 1 || I2S_DELAY < 1) begin : g_bad_delay
      $error("clip_slot_mux: reload delays must be at least one bit period");
   end
   if (MAX_DELAY > 15) begin : g_long_delay
      $error("clip_slot_mux: reload delay must stay well inside the setup margin");
   end

   logic [TMR_W-1:0] wait_cnt;
   logic [TMR_W-1:0] load_val;
   logic             lrck_q;
   logic             pick_left;
   logic             drive_q;
   logic             edge_seen;

   if (LJ_DELAY == I2S_DELAY) begin : g_same_delay
      assign load_val = TMR_W'(LJ_DELAY);
   end else begin : g_fmt_delay
      assign load_val = fmt_i2s ? TMR_W'(I2S_DELAY) : TMR_W'(LJ_DELAY);
   end

   assign edge_seen = (lrck != lrck_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lrck_q    <= 1'b0;
         wait_cnt  <= '0;
         pick_left <= 1'b0;
         drive_q   <= 1'b0;
      end else if (sclk_stb) begin
         lrck_q <= lrck;
         if (wait_cnt == TMR_W'(1))
            drive_q <= pick_left ? flags[CH_L] : flags[CH_R];
         if (edge_seen) begin
            wait_cnt  <= load_val;
            // left-justified: high half is left; I2S: high half is right
            pick_left <= lrck ^ fmt_i2s;
         end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - TMR_W'(1);
         end
      end
   end

   assign line_pull_low = drive_q;

endmodule

// File: rtl/clip_flag_serializer.sv
module clip_flag_serializer
   import clip_flag_pkg::*;
#(
   parameter int HOLD_BASE = 32768,
   parameter int LJ_DELAY  = 1,
   parameter int I2S_DELAY = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_stb,
   input  logic       lrck,
   input  logic       fmt_i2s,
   input  logic [1:0] speed_mode,
   input  logic       sample_stb,
   input  logic       ovr_left,
   input  logic       ovr_right,
   output logic       line_pull_low
);

   localparam int CNT_W = $clog2(HOLD_BASE * 4 + 1);

   logic [NUM_CH-1:0] ovr_vec;
   logic [NUM_CH-1:0] hold_flags;

   assign ovr_vec[CH_L] = ovr_left;
   assign ovr_vec[CH_R] = ovr_right;

   clip_hold_timer #(
      .HOLD_BASE (HOLD_BASE),
      .CNT_W     (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .ovr        (ovr_vec),
      .speed_mode (speed_mode),
      .flags      (hold_flags)
   );

   clip_slot_mux #(
      .LJ_DELAY  (LJ_DELAY),
      .I2S_DELAY (I2S_DELAY)
   ) u_mux (
      .clk           (clk),
      .rst_n         (rst_n),
      .sclk_stb      (sclk_stb),
      .lrck          (lrck),
      .fmt_i2s       (fmt_i2s),
      .flags         (hold_flags),
      .line_pull_low (line_pull_low)
   );

endmodule

// File: rtl/clip_flag_checker.sv
module clip_flag_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sclk_stb,
   input logic       sample_stb,
   input logic       ovr_left,
   input logic       ovr_right,
   input logic [1:0] flags,
   input logic       line_pull_low
);

   assert_set_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && ovr_left) |=> flags[0]);

   assert_set_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && ovr_right) |=> flags[1]);

   assert_no_spurious_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(sample_stb && ovr_left));

   assert_no_spurious_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> $past(sample_stb && ovr_right));

   assert_joint_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flags[0]) || $fell(flags[1])) |-> (flags == 2'b00));

   assert_clear_on_quiet_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flags[0]) || $fell(flags[1])) |-> $past(sample_stb && !ovr_left && !ovr_right));

   assert_bit_timed_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_pull_low) |-> $past(sclk_stb));

   assert_pull_from_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_pull_low) |-> $past(flags != 2'b00));

endmodule

bind clip_flag_serializer clip_flag_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sclk_stb      (sclk_stb),
   .sample_stb    (sample_stb),
   .ovr_left      (ovr_left),
   .ovr_right     (ovr_right),
   .flags         (hold_flags),
   .line_pull_low (line_pull_low)
);

// File: tb/test_clip_flag_serializer.sv
module test_clip_flag_serializer;

   localparam int CLK_PERIOD = 10;
   localparam int HB         = 3;
   localparam int FRAME      = 256;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sclk_stb;
   logic       lrck;
   logic       fmt_i2s;
   logic [1:0] speed_mode;
   logic       sample_stb;
   logic       ovr_left;
   logic       ovr_right;
   logic       line_pull_low;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 0;
   string tag;

   // stimulus requests
   bit pend_l, pend_r, stray_l;

   // behavioural reference state
   bit m_fl_l, m_fl_r, m_out, m_lr_prev, m_sel_left;
   int m_remain, m_wait;

   always #(CLK_PERIOD/2) clk = ~clk;

   clip_flag_serializer #(.HOLD_BASE(HB)) i_clip_flag_serializer (
      .clk           (clk),
      .rst_n         (rst_n),
      .sclk_stb      (sclk_stb),
      .lrck          (lrck),
      .fmt_i2s       (fmt_i2s),
      .speed_mode    (speed_mode),
      .sample_stb    (sample_stb),
      .ovr_left      (ovr_left),
      .ovr_right     (ovr_right),
      .line_pull_low (line_pull_low)
   );

   function automatic int window_len(input logic [1:0] mode);
      case (mode)
         2'd1:    return HB * 2;
         2'd2:    return HB * 4;
         default: return HB;
      endcase
   endfunction

   task automatic model_reset();
      m_fl_l = 0; m_fl_r = 0; m_out = 0; m_lr_prev = 0;
      m_sel_left = 0; m_remain = 0; m_wait = 0;
   endtask

   // state after the coming clock edge, from the inputs now applied
   task automatic model_step();
      bit old_l, old_r;
      old_l = m_fl_l;
      old_r = m_fl_r;
      if (sample_stb) begin
         if (ovr_left || ovr_right) begin
            m_remain = window_len(speed_mode);
            if (ovr_left)  m_fl_l = 1;
            if (ovr_right) m_fl_r = 1;
         end else if (m_remain > 0) begin
            m_remain--;
            if (m_remain == 0) begin
               m_fl_l = 0;
               m_fl_r = 0;
            end
         end
      end
      if (sclk_stb) begin
         if (m_wait == 1) m_out = m_sel_left ? old_l : old_r;
         if (lrck != m_lr_prev) begin
            m_wait     = fmt_i2s ? 2 : 1;
            m_sel_left = lrck ^ fmt_i2s;
         end else if (m_wait > 0) begin
            m_wait--;
         end
         m_lr_prev = lrck;
      end
   endtask

   task automatic check_line(input string req, input bit exp);
      checks++;
      if (line_pull_low !== exp) begin
         errors++;
         $display("FAIL %s: line_pull_low=%0b expected %0b at cycle %0d",
                  req, line_pull_low, exp, cyc);
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_line(tag, m_out);
         sclk_stb   = ((cyc % 4) == 3);
         lrck       = (((cyc / 4) % 64) < 32);
         sample_stb = ((cyc % FRAME) == 10);
         ovr_left   = 0;
         ovr_right  = 0;
         if (sample_stb) begin
            ovr_left  = pend_l;
            ovr_right = pend_r;
            pend_l = 0;
            pend_r = 0;
         end else if (stray_l && (cyc % 4) == 1) begin
            ovr_left = 1;
         end
         model_step();
         cyc++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, cycle %0d", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; sclk_stb = 0; lrck = 0; fmt_i2s = 0; speed_mode = 0;
      sample_stb = 0; ovr_left = 0; ovr_right = 0;
      pend_l = 0; pend_r = 0; stray_l = 0;
      model_reset();
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check_line("R1", 1'b0);
      end
      rst_n = 1;

      tag = "R1"; run(FRAME);

      // left-justified, single speed, left channel only
      tag = "R2 R5 R6"; pend_l = 1; run(FRAME * 7);

      // overrange pulses outside the sample strobe must not set anything
      tag = "R2"; stray_l = 1; run(FRAME * 3); stray_l = 0;

      // right flagged, then left reported two frames later: shared restart
      tag = "R4"; pend_r = 1; run(FRAME * 2);
      pend_l = 1; run(FRAME * 8);

      // I2S polarity and two-strobe reload, double speed, both channels
      fmt_i2s = 1; speed_mode = 2'd1;
      tag = "R5 R6 R7"; pend_l = 1; pend_r = 1; run(FRAME * 10);
      tag = "R5"; pend_r = 1; run(FRAME * 10);

      // hold length for quad speed and the reserved code
      tag = "R3"; speed_mode = 2'd2; pend_r = 1; run(FRAME * 16);
      speed_mode = 2'd3; fmt_i2s = 0; pend_l = 1; run(FRAME * 6);
      speed_mode = 2'd0; pend_r = 1; run(FRAME * 6);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule